// File: doc/BRIEF.md
# Hardware Cursor Overlay Generator

This block draws a small two-colour pointer on top of a raster pixel stream. Software programs it through a 32-bit register port. It writes the cursor position, a 32-row transparency plane (mask) and a 32-row colour plane, and it can store and read back a general control word. On the pixel side, the timing logic upstream presents the current column and row counters together with a valid strobe. One clock later the block returns a two-bit overlay select for that pixel. The downstream mux uses that select either to keep the underlying pixel or to replace it with one of two overlay palette entries, numbered 258 and 259.

A mask bit of 1 makes the cursor opaque at that pixel. The matching colour bit then picks between the two overlay entries. Each row word is scanned from its most significant bit, and bit 31 sits at the cursor's own column. After reset the cursor sits at coordinate 0xF000 on both axes, which is far beyond any visible raster, so nothing is drawn until software moves it.

Top module: `cursor_overlay`

## Requirements
- R1: A write to offset 0x8FC loads cursor x from write data bits [31:16] and cursor y from bits [15:0].
- R2: A write to a word-aligned offset from 0x900 through 0x97C loads transparency row (offset - 0x900) >> 2.
- R3: A write to a word-aligned offset from 0x980 through 0x9FC loads colour row (offset - 0x980) >> 2. It leaves the transparency plane untouched.
- R4: A pixel row takes part in the cursor only when pixel y lies within [cursor y, cursor y + 32) and below the screen height (parameter, default 768). All other rows give select 0.
- R5: Within an active row, the column cursor x + k uses bit 31 - k of that row, for k from 0 to 31. Columns left of cursor x or beyond cursor x + 31 give select 0.
- R6: The overlay select encodes as follows: 0 means no overlay. 1 means entry 258 (mask 1, colour 0). 2 means entry 259 (mask 1, colour 1). Value 3 never appears. A clear mask bit gives 0.
- R7: Columns at or beyond the screen width (parameter, default 1024) always give select 0. A cursor near the right edge is therefore clipped.
- R8: Reset sets both cursor coordinates to 0xF000 and clears both planes. Before software moves the cursor, no pixel gets an overlay.
- R9: A read of offset 0x818 returns the last value written there, ORed with 0x02000000, on reg_rdata in the cycle after the read strobe.
- R10: A read of any other offset returns zero in the cycle after the strobe. reg_rdata is zero in cycles that follow no read.
- R11: ovl_sel is registered. It reflects the pixel presented one cycle earlier, and it is 0 after a cycle in which pix_valid was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd_en |
| pix_valid | input | 1 | Pixel coordinates are valid this cycle |
| pix_x | input | 16 | Current pixel column |
| pix_y | input | 16 | Current pixel row |
| ovl_sel | output | 2 | Overlay select: 0 none, 1 entry 258, 2 entry 259 |

## Verification
The assertions assume two things about the inputs. Read and write strobes are never raised in the same cycle. The pixel coordinates hold steady within a cycle. The window and clipping checks relate the pixel inputs and the cursor position sampled in one cycle to the select seen in the next. The stimulus raises one strobe at a time, changes every input on the falling edge, and leaves the cursor position unchanged while pixels are being checked. As a result, each expected select follows only from the programmed position and rows.

// File: rtl/cursor_pkg.sv
// Shared constants for the cursor overlay: register offsets and select codes.
package cursor_pkg;
    localparam int unsigned ADDR_W = 12;
    localparam int unsigned DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_MISC  = 12'h818;
    localparam logic [ADDR_W-1:0] OFS_POS   = 12'h8FC;
    localparam logic [ADDR_W-1:0] OFS_MASK  = 12'h900;
    localparam logic [ADDR_W-1:0] OFS_COLOR = 12'h980;

    localparam logic [DATA_W-1:0] MISC_FORCED = 32'h0200_0000;
    localparam logic [15:0]       POS_HIDDEN  = 16'hF000;

    localparam logic [1:0] SEL_NONE = 2'd0;
    localparam logic [1:0] SEL_C258 = 2'd1;
    localparam logic [1:0] SEL_C259 = 2'd2;
endpackage

// File: rtl/cursor_regs.sv
// Position and control registers with a registered read port.
// Assumes reads and writes are never strobed in the same cycle.
module cursor_regs
    import cursor_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [15:0]       cur_x,
    output logic [15:0]       cur_y,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] misc_q;

    // Load position and control word on writes to their offsets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_x  <= POS_HIDDEN;
            cur_y  <= POS_HIDDEN;
            misc_q <= '0;
        end else if (wr_en) begin
            if (addr == OFS_POS) begin
                cur_x <= wdata[31:16];
                cur_y <= wdata[15:0];
            end
            if (addr == OFS_MISC) begin
                misc_q <= wdata;
            end
        end
    end

    // Return the control word with its forced bit; every other offset reads zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en && addr == OFS_MISC) begin
            rdata <= misc_q | MISC_FORCED;
        end else begin
            rdata <= '0;
        end
    end

    assert_pos_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_POS) |=> (cur_x == $past(wdata[31:16]) && cur_y == $past(wdata[15:0])));
    assert_misc_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == OFS_MISC) |=> rdata[25]);
    assert_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!(rd_en && addr == OFS_MISC)) |=> (rdata == '0));
endmodule

// File: rtl/cursor_planes.sv
// Two planes of cursor rows: the transparency plane and the colour plane.
// A generate loop builds one storage plane per region; both read out the same row.
// Assumes word-aligned offsets; unaligned writes are dropped.
module cursor_planes
    import cursor_pkg::*;
#(
    parameter int unsigned DIM = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [DATA_W-1:0]      wdata,
    input  logic [$clog2(DIM)-1:0] row_idx,
    output logic [DIM-1:0]         mask_row,
    output logic [DIM-1:0]         color_row
);
    localparam int unsigned ROW_W  = $clog2(DIM);
    localparam int unsigned REG_LO = ROW_W + 2;
    localparam int unsigned NPLANE = 2;

    logic [DIM-1:0] plane_q [NPLANE][DIM];
    logic [NPLANE-1:0] hit;

    for (genvar p = 0; p < NPLANE; p++) begin : g_plane
        localparam logic [ADDR_W-1:0] BASE = (p == 0) ? OFS_MASK : OFS_COLOR;
        assign hit[p] = wr_en && (addr[1:0] == 2'b00)
                        && (addr[ADDR_W-1:REG_LO] == BASE[ADDR_W-1:REG_LO]);

        // Store one row word when a write lands in this plane's region.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int r = 0; r < DIM; r++) plane_q[p][r] <= '0;
            end else if (hit[p]) begin
                plane_q[p][addr[REG_LO-1:2]] <= wdata[DIM-1:0];
            end
        end
    end

    assign mask_row  = plane_q[0][row_idx];
    assign color_row = plane_q[1][row_idx];

    assert_mask_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hit[0] |=> (plane_q[0][$past(addr[REG_LO-1:2])] == $past(wdata[DIM-1:0])));
    assert_color_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit[1] |=> $stable(plane_q[0][$past(addr[REG_LO-1:2])]));
endmodule

// File: rtl/cursor_pixel.sv
// Per-pixel hit test and registered overlay select.
// Assumes the cursor position and the pixel coordinates are stable within a cycle.
module cursor_pixel
    import cursor_pkg::*;
#(
    parameter int unsigned WIDTH  = 1024,
    parameter int unsigned HEIGHT = 768,
    parameter int unsigned DIM    = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pix_valid,
    input  logic [15:0]            pix_x,
    input  logic [15:0]            pix_y,
    input  logic [15:0]            cur_x,
    input  logic [15:0]            cur_y,
    input  logic [DIM-1:0]         mask_row,
    input  logic [DIM-1:0]         color_row,
    output logic [$clog2(DIM)-1:0] row_idx,
    output logic [1:0]             ovl_sel
);
    localparam int unsigned ROW_W = $clog2(DIM);

    logic [16:0]      dx, dy;
    logic             row_hit, col_hit;
    logic [ROW_W-1:0] bit_idx;
    logic [1:0]       sel_d;

    // Offsets of the pixel from the cursor origin and the window tests.
    always_comb begin
        dx      = {1'b0, pix_x} - {1'b0, cur_x};
        dy      = {1'b0, pix_y} - {1'b0, cur_y};
        row_hit = !dy[16] && (dy[15:0] < 16'(DIM)) && (32'(pix_y) < HEIGHT);
        col_hit = !dx[16] && (dx[15:0] < 16'(DIM)) && (32'(pix_x) < WIDTH);
        row_idx = dy[ROW_W-1:0];
        bit_idx = ROW_W'(DIM - 1) - dx[ROW_W-1:0];
    end

    // Pick the overlay entry from the mask and colour bits of this pixel.
    always_comb begin
        sel_d = SEL_NONE;
        if (pix_valid && row_hit && col_hit && mask_row[bit_idx]) begin
            sel_d = color_row[bit_idx] ? SEL_C259 : SEL_C258;
        end
    end

    // Register the select for one cycle of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) ovl_sel <= SEL_NONE;
        else        ovl_sel <= sel_d;
    end

    assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> (ovl_sel == SEL_NONE));
    assert_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> (ovl_sel != 2'd3));
    assert_clip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && 32'(pix_x) >= WIDTH) |=> (ovl_sel == SEL_NONE));
    assert_above_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_y < cur_y) |=> (ovl_sel == SEL_NONE));
    assert_left_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_x < cur_x) |=> (ovl_sel == SEL_NONE));
endmodule

// File: rtl/cursor_overlay.sv
// Top of the hardware cursor overlay: register port, row planes, pixel test.
// Assumes a single clock domain shared by the register and pixel sides.
module cursor_overlay
    import cursor_pkg::*;
#(
    parameter int unsigned WIDTH  = 1024,
    parameter int unsigned HEIGHT = 768,
    parameter int unsigned DIM    = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic        reg_rd_en,
    input  logic [11:0] reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        pix_valid,
    input  logic [15:0] pix_x,
    input  logic [15:0] pix_y,
    output logic [1:0]  ovl_sel
);
    localparam int unsigned ROW_W = $clog2(DIM);

    logic [15:0]      cur_x, cur_y;
    logic [ROW_W-1:0] row_idx;
    logic [DIM-1:0]   mask_row, color_row;

    cursor_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .rd_en(reg_rd_en),
        .addr(reg_addr), .wdata(reg_wdata),
        .cur_x(cur_x), .cur_y(cur_y), .rdata(reg_rdata)
    );

    cursor_planes #(.DIM(DIM)) u_planes (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
        .wdata(reg_wdata), .row_idx(row_idx),
        .mask_row(mask_row), .color_row(color_row)
    );

    cursor_pixel #(.WIDTH(WIDTH), .HEIGHT(HEIGHT), .DIM(DIM)) u_pixel (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid),
        .pix_x(pix_x), .pix_y(pix_y), .cur_x(cur_x), .cur_y(cur_y),
        .mask_row(mask_row), .color_row(color_row),
        .row_idx(row_idx), .ovl_sel(ovl_sel)
    );

    assert_no_dual_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_en && reg_rd_en));
endmodule

// File: tb/sim_cursor_overlay.sv
module sim_cursor_overlay;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pix_valid = 1'b0;
    logic [15:0] pix_x = '0, pix_y = '0;
    logic [1:0]  ovl_sel;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    cursor_overlay u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y), .ovl_sel(ovl_sel)
    );

    // Vector: x, y, expected select. Cursor at (100,50); rows set up below.
    localparam logic [33:0] VEC [12] = '{
        {16'd100, 16'd50, 2'd2},  // R5 R6: bit31 mask1 colour1
        {16'd131, 16'd50, 2'd1},  // R5 R6: bit0 mask1 colour0
        {16'd101, 16'd50, 2'd0},  // R6: mask clear
        {16'd99,  16'd50, 2'd0},  // R5: left of cursor
        {16'd132, 16'd50, 2'd0},  // R5: right of cursor
        {16'd100, 16'd49, 2'd0},  // R4: above window
        {16'd100, 16'd81, 2'd1},  // R2 R3: last row, bit31 colour0
        {16'd131, 16'd81, 2'd2},  // R3: last row, bit0 colour1
        {16'd115, 16'd81, 2'd1},  // R5: bit16
        {16'd116, 16'd81, 2'd2},  // R5: bit15
        {16'd100, 16'd82, 2'd0},  // R4: below window
        {16'd100, 16'd60, 2'd0}   // R2: unwritten row
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_rd_en = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd_en = 1'b0;
        check(tag, reg_rdata, exp);
    endtask

    task automatic pixel(input logic v, input logic [15:0] x, input logic [15:0] y,
                         input logic [1:0] exp, input string tag);
        @(negedge clk);
        pix_valid = v; pix_x = x; pix_y = y;
        @(negedge clk);
        pix_valid = 1'b0;
        check(tag, 32'(ovl_sel), 32'(exp));
    endtask

    initial begin
        #500us;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 reset select", 32'(ovl_sel), 32'd0);
        check("R10 reset rdata", reg_rdata, 32'd0);

        // R8: planes filled, position untouched, so nothing is drawn.
        reg_write(12'h900, 32'hFFFF_FFFF);
        pixel(1'b1, 16'd0, 16'd0, 2'd0, "R8 hidden at origin");
        pixel(1'b1, 16'hF000, 16'hF000, 2'd0, "R8 hidden at reset position");

        // Program the table setup: position (100,50).
        reg_write(12'h8FC, {16'd100, 16'd50});                // R1
        reg_write(12'h900, 32'h8000_0001);                     // R2 row 0
        reg_write(12'h980, 32'h8000_0000);                     // R3 row 0
        reg_write(12'h97C, 32'hFFFF_FFFF);                     // R2 row 31
        reg_write(12'h9FC, 32'h0000_FFFF);                     // R3 row 31
        for (int i = 0; i < 12; i++) begin
            pixel(1'b1, VEC[i][33:18], VEC[i][17:2], VEC[i][1:0],
                  $sformatf("R1 R4 R5 R6 vector %0d", i));
        end

        // R11: valid low suppresses an otherwise hit pixel.
        pixel(1'b0, 16'd100, 16'd50, 2'd0, "R11 valid low");
        pixel(1'b1, 16'd100, 16'd50, 2'd2, "R11 latency one cycle");

        // R9 / R10: register read port.
        reg_write(12'h818, 32'h0000_0055);
        reg_read(12'h818, 32'h0200_0055, "R9 misc readback");
        reg_read(12'h8FC, 32'h0, "R10 position reads zero");
        reg_read(12'h900, 32'h0, "R10 plane reads zero");

        // R7: clip at the right edge with cursor x = 1000.
        reg_write(12'h8FC, {16'd1000, 16'd0});
        reg_write(12'h900, 32'hFFFF_FFFF);
        reg_write(12'h980, 32'h0000_0000);
        pixel(1'b1, 16'd1023, 16'd0, 2'd1, "R7 last visible column");
        pixel(1'b1, 16'd1024, 16'd0, 2'd0, "R7 clipped column");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule